// File: doc/BRIEF.md
# Flash Read Cache Timing Controller

This block sits between a processor read port and a slow flash array. A small direct-mapped cache answers repeated reads. Every read that reaches the array is held for a programmable number of extra cycles. A read-policy input chooses how those cycles are spent:

- **Fastest:** a miss costs only the programmed flash wait.
- **Low-power:** a miss costs one extra cycle.
- **Constant-latency:** a hit is stretched to take exactly as long as a miss, so execution timing does not depend on cache contents.

The block also manages the flash low-power state across system sleep. There are two wake-up policies. In one, the flash wakes on the first read after sleep. In the other, it wakes as soon as sleep ends. Automatic power reduction can also be switched off entirely.

The processor side uses a valid/ready request handshake. Read data comes back with a one-cycle response strobe. The flash side presents an address and a read-enable. The array returns its word combinationally, and the controller samples it in the last cycle of the stretched access.

Top module: `flash_rdcache_ctrl`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, and `cpu_rsp_valid`, `fl_rd_en` and `fl_lowpwr` are 0.
- R2: Latency is counted as follows: the request is accepted in cycle A, and `cpu_rsp_valid` is high in cycle A+N. With read policy 0 and wait count W, a miss gives N = W+2. The response data equals the flash word at the request address, and the array is read once.
- R3: With read policy 0, a hit on a cached address gives N = 1, returns the same data, and raises no flash read.
- R4: With read policy 1, a miss gives N = W+3 and a hit gives N = 1.
- R5: With read policy 2, a hit and a miss both give N = W+2, and a hit still raises no flash read.
- R6: Read policy 3 is timed exactly as policy 0.
- R7: While `cfg_cache_off` is 1, every read goes to the flash with miss timing. Leaving that state finds every line invalid.
- R8: The cache has 16 one-word lines. The line index is the low 4 bits of the word address, and the tag is the remaining upper bits. Two addresses that share an index evict each other.
- R9: `cpu_rsp_valid` is high for exactly one cycle per accepted read. `cpu_req_ready` is 0 while a read is in progress.
- R10: With sleep policy 0, the flash goes to low power (`fl_lowpwr`=1) one cycle after `sleep_req` rises. It stays in low power after sleep ends, until a request is presented. That request is accepted 3 cycles after it is first presented: 1 detection cycle plus 2 wake cycles. `cpu_req_ready` is 0 throughout.
- R11: With sleep policy 1, `fl_lowpwr` falls one cycle after `sleep_req` falls. `cpu_req_ready` returns two cycles later, before any access.
- R12: With sleep policy 3, and with reserved policy 2, `fl_lowpwr` never rises. Reads are served during sleep without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cache_off | input | 1 | 1 bypasses the cache and invalidates all lines |
| cfg_read_mode | input | 2 | Read policy: 0 fastest, 1 low-power, 2 constant latency, 3 as 0 |
| cfg_wait_cnt | input | 4 | Extra cycles per flash access |
| cfg_sleep_mode | input | 2 | Sleep policy: 0 wake on access, 1 wake on sleep exit, 2/3 no power reduction |
| sleep_req | input | 1 | High while the system sleeps |
| cpu_req_valid | input | 1 | Read request present |
| cpu_req_addr | input | 12 | Word address of the read |
| cpu_req_ready | output | 1 | Request accepted when high together with valid |
| cpu_rsp_valid | output | 1 | One-cycle strobe marking read data |
| cpu_rsp_data | output | 32 | Read data |
| fl_rd_en | output | 1 | Flash array read in progress |
| fl_addr | output | 12 | Flash array word address |
| fl_rdata | input | 32 | Flash array data, combinational from address |
| fl_lowpwr | output | 1 | Flash held in low-power state |

## Verification
The main read path is exercised in several ways:

- A first read of an address followed by a repeat read separates miss timing from hit timing under each read policy. The expected latencies are distinct for each policy, so any swap of policy decoding is caught.
- Counting rising edges of the flash read-enable distinguishes hits served from the cache from reads that touched the array.
- Pairs of addresses sharing an index expose tag comparison and eviction.
- A cached address reread while the cache is bypassed, and again after bypass ends, shows the invalidation.

Sleep sequences under each policy measure how many cycles a request stalls. They also measure when the low-power output falls, which separates wake-on-access from wake-on-exit and from no power reduction.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam logic [1:0] RM_FAST  = 2'd0;
    localparam logic [1:0] RM_LOWPW = 2'd1;
    localparam logic [1:0] RM_CONST = 2'd2;

    localparam logic [1:0] SM_WAKE_ON_ACCESS = 2'd0;
    localparam logic [1:0] SM_WAKE_ON_EXIT   = 2'd1;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_FLASH = 2'd1,
        ACC_HOLD  = 2'd2
    } acc_state_e;

    typedef enum logic [1:0] {
        PW_ON   = 2'd0,
        PW_LOW  = 2'd1,
        PW_WAKE = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/frc_timing_policy.sv
module frc_timing_policy #(
    parameter int WS_W = 4
) (
    input  logic [1:0]    read_mode,
    input  logic [WS_W-1:0] wait_cnt,
    output logic [WS_W:0] miss_cnt,
    output logic [WS_W:0] hit_cnt,
    output logic          hit_slow
);
    import frc_pkg::*;

    logic lowpw_sel;
    logic const_sel;

    always_comb begin
        // reserved policy 3 falls through to the fastest policy
        lowpw_sel = (read_mode == RM_LOWPW);
        const_sel = (read_mode == RM_CONST);
        miss_cnt  = {1'b0, wait_cnt} + {{WS_W{1'b0}}, lowpw_sel};
        hit_cnt   = {1'b0, wait_cnt};
        hit_slow  = const_sel;
    end
endmodule

// File: rtl/frc_line_store.sv
module frc_line_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [LINES-1:0]             vld;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] dat;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.vld[fill_idx] = 1'b1;
            st_d.tag[fill_idx] = fill_tag;
            st_d.dat[fill_idx] = fill_data;
        end
        if (flush) begin
            st_d.vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        lk_hit  = st_q.vld[lk_idx] && (st_q.tag[lk_idx] == lk_tag);
        lk_data = st_q.dat[lk_idx];
    end

    // R7: after a cycle of bypass, no line may report a hit
    p_off_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && $past(flush)) |-> !lk_hit);
endmodule

// File: rtl/frc_pwr_ctl.sv
module frc_pwr_ctl #(
    parameter int WAKE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic [1:0] sleep_mode,
    input  logic       busy,
    input  logic       req_valid,
    output logic       grant,
    output logic       lowpwr
);
    import frc_pkg::*;

    localparam int WK_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [WK_W-1:0] WK_LOAD = WK_W'(WAKE_CYC - 1);

    typedef struct packed {
        pwr_state_e       st;
        logic [WK_W-1:0]  cnt;
    } pwr_t;

    pwr_t pw_d, pw_q;
    logic lp_on;
    logic wake_go;

    always_comb begin
        lp_on   = (sleep_mode == SM_WAKE_ON_ACCESS) || (sleep_mode == SM_WAKE_ON_EXIT);
        wake_go = 1'b0;
        pw_d    = pw_q;
        case (pw_q.st)
            PW_ON: begin
                if (sleep_req && lp_on && !busy) begin
                    pw_d.st = PW_LOW;
                end
            end
            PW_LOW: begin
                if (!lp_on) begin
                    wake_go = 1'b1;
                end else if (!sleep_req) begin
                    wake_go = (sleep_mode == SM_WAKE_ON_EXIT) || req_valid;
                end
                if (wake_go) begin
                    pw_d.st  = PW_WAKE;
                    pw_d.cnt = WK_LOAD;
                end
            end
            PW_WAKE: begin
                if (pw_q.cnt == '0) begin
                    pw_d.st = PW_ON;
                end else begin
                    pw_d.cnt = pw_q.cnt - 1'b1;
                end
            end
            default: pw_d.st = PW_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q <= '{st: PW_ON, cnt: '0};
        end else begin
            pw_q <= pw_d;
        end
    end

    always_comb begin
        lowpwr = (pw_q.st == PW_LOW);
        grant  = (pw_q.st == PW_ON) && !(sleep_req && lp_on);
    end

    // R10: no request may be granted while the array sleeps
    p_low_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr |-> !grant);

    // R11: with wake-on-exit, sleep ending starts the wake sequence next cycle
    p_exit_wakes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lowpwr && sleep_mode == SM_WAKE_ON_EXIT && !sleep_req) |=> !lowpwr);

    // R12: with power reduction off, the array never enters low power
    p_no_lowpwr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!lowpwr && !lp_on) |=> !lowpwr);
endmodule

// File: rtl/flash_rdcache_ctrl.sv
module flash_rdcache_ctrl #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int WS_W     = 4,
    parameter int WAKE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cache_off,
    input  logic [1:0]        cfg_read_mode,
    input  logic [WS_W-1:0]   cfg_wait_cnt,
    input  logic [1:0]        cfg_sleep_mode,
    input  logic              sleep_req,
    input  logic              cpu_req_valid,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_data,
    output logic              fl_rd_en,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              fl_lowpwr
);
    import frc_pkg::*;

    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int CNT_W = WS_W + 1;

    typedef struct packed {
        acc_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_data;
    } acc_t;

    acc_t ac_d, ac_q;

    logic              hit_w;
    logic [DATA_W-1:0] hit_data;
    logic [CNT_W-1:0]  miss_cnt;
    logic [CNT_W-1:0]  hit_cnt;
    logic              hit_slow;
    logic              pwr_grant;
    logic              accept;
    logic              hit_use;
    logic              fill_en;

    frc_timing_policy #(.WS_W(WS_W)) u_policy (
        .read_mode (cfg_read_mode),
        .wait_cnt  (cfg_wait_cnt),
        .miss_cnt  (miss_cnt),
        .hit_cnt   (hit_cnt),
        .hit_slow  (hit_slow)
    );

    frc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cfg_cache_off),
        .lk_idx    (cpu_req_addr[IDX_W-1:0]),
        .lk_tag    (cpu_req_addr[ADDR_W-1:IDX_W]),
        .lk_hit    (hit_w),
        .lk_data   (hit_data),
        .fill_en   (fill_en),
        .fill_idx  (ac_q.addr[IDX_W-1:0]),
        .fill_tag  (ac_q.addr[ADDR_W-1:IDX_W]),
        .fill_data (fl_rdata)
    );

    frc_pwr_ctl #(.WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .sleep_mode (cfg_sleep_mode),
        .busy       (ac_q.st != ACC_IDLE),
        .req_valid  (cpu_req_valid),
        .grant      (pwr_grant),
        .lowpwr     (fl_lowpwr)
    );

    always_comb begin
        cpu_req_ready = (ac_q.st == ACC_IDLE) && pwr_grant;
        accept        = cpu_req_valid && cpu_req_ready;
        hit_use       = hit_w && !cfg_cache_off;
        fill_en       = (ac_q.st == ACC_FLASH) && (ac_q.cnt == '0) && !cfg_cache_off;

        ac_d       = ac_q;
        ac_d.rsp_v = 1'b0;
        case (ac_q.st)
            ACC_IDLE: begin
                if (accept) begin
                    ac_d.addr = cpu_req_addr;
                    if (hit_use && !hit_slow) begin
                        ac_d.rsp_v    = 1'b1;
                        ac_d.rsp_data = hit_data;
                    end else if (hit_use) begin
                        ac_d.st       = ACC_HOLD;
                        ac_d.cnt      = hit_cnt;
                        ac_d.rsp_data = hit_data;
                    end else begin
                        ac_d.st  = ACC_FLASH;
                        ac_d.cnt = miss_cnt;
                    end
                end
            end
            ACC_FLASH: begin
                if (ac_q.cnt == '0) begin
                    ac_d.st       = ACC_IDLE;
                    ac_d.rsp_v    = 1'b1;
                    ac_d.rsp_data = fl_rdata;
                end else begin
                    ac_d.cnt = ac_q.cnt - 1'b1;
                end
            end
            ACC_HOLD: begin
                if (ac_q.cnt == '0) begin
                    ac_d.st    = ACC_IDLE;
                    ac_d.rsp_v = 1'b1;
                end else begin
                    ac_d.cnt = ac_q.cnt - 1'b1;
                end
            end
            default: ac_d.st = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q <= '{st: ACC_IDLE, cnt: '0, addr: '0, rsp_v: 1'b0, rsp_data: '0};
        end else begin
            ac_q <= ac_d;
        end
    end

    always_comb begin
        cpu_rsp_valid = ac_q.rsp_v;
        cpu_rsp_data  = ac_q.rsp_data;
        fl_rd_en      = (ac_q.st == ACC_FLASH);
        fl_addr       = ac_q.addr;
    end

    // R3: a hit served without stretching must not touch the array
    p_hit_no_flash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_w && !cfg_cache_off && !hit_slow) |=> !fl_rd_en);

    // R10: the array is never read while in low power
    p_idle_flash_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fl_lowpwr |-> !fl_rd_en);

    // R9: no new request is taken while a response is still pending
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_en |-> !cpu_req_ready);
endmodule

// File: tb/flash_rdcache_ctrl_bench.sv
module flash_rdcache_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cache_off = 1'b0;
    logic [1:0]  cfg_read_mode = 2'd0;
    logic [3:0]  cfg_wait_cnt = 4'd0;
    logic [1:0]  cfg_sleep_mode = 2'd3;
    logic        sleep_req = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic [11:0] cpu_req_addr = '0;
    logic        cpu_req_ready;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_data;
    logic        fl_rd_en;
    logic [11:0] fl_addr;
    logic [31:0] fl_rdata;
    logic        fl_lowpwr;

    int n_checks = 0;
    int n_fails  = 0;
    int fl_reads = 0;
    logic fl_prev = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [31:0] flash_word(input logic [11:0] a);
        return {20'hC0DE5, a};
    endfunction

    assign fl_rdata = fl_rd_en ? flash_word(fl_addr) : 32'h0;

    always @(posedge clk) begin
        fl_prev <= fl_rd_en;
        if (fl_rd_en && !fl_prev) fl_reads <= fl_reads + 1;
    end

    flash_rdcache_ctrl u_flash_rdcache_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_cache_off  (cfg_cache_off),
        .cfg_read_mode  (cfg_read_mode),
        .cfg_wait_cnt   (cfg_wait_cnt),
        .cfg_sleep_mode (cfg_sleep_mode),
        .sleep_req      (sleep_req),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_rsp_valid  (cpu_rsp_valid),
        .cpu_rsp_data   (cpu_rsp_data),
        .fl_rd_en       (fl_rd_en),
        .fl_addr        (fl_addr),
        .fl_rdata       (fl_rdata),
        .fl_lowpwr      (fl_lowpwr)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // issue one read; stall = cycles waiting for ready, lat = N per the requirements
    task automatic do_read(input logic [11:0] a, output int stall, output int lat,
                           output logic [31:0] data, output int reads);
        int r0;
        r0 = fl_reads;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        stall = 0;
        while (!cpu_req_ready) begin
            @(negedge clk);
            stall++;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 1;
        while (!cpu_rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        data  = cpu_rsp_data;
        reads = fl_reads - r0;
    endtask

    task automatic read_chk(input string req, input logic [11:0] a, input int exp_lat,
                            input int exp_reads);
        int s, l, r;
        logic [31:0] d;
        do_read(a, s, l, d, r);
        chk(req, "latency", l, exp_lat);
        chk(req, "data", d, flash_word(a));
        chk(req, "flash reads", r, exp_reads);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready", cpu_req_ready, 1);
        chk("R1", "rsp_valid", cpu_rsp_valid, 0);
        chk("R1", "fl_rd_en", fl_rd_en, 0);
        chk("R1", "fl_lowpwr", fl_lowpwr, 0);
    endtask

    task automatic t_policy_fast();
        cfg_read_mode = 2'd0; cfg_wait_cnt = 4'd3;
        read_chk("R2", 12'h010, 5, 1);
        read_chk("R3", 12'h010, 1, 0);
        cfg_wait_cnt = 4'd0;
        read_chk("R2", 12'h021, 2, 1);
        read_chk("R3", 12'h021, 1, 0);
    endtask

    task automatic t_policy_lowpw();
        cfg_read_mode = 2'd1; cfg_wait_cnt = 4'd2;
        read_chk("R4", 12'h032, 5, 1);
        read_chk("R4", 12'h032, 1, 0);
    endtask

    task automatic t_policy_const();
        cfg_read_mode = 2'd2; cfg_wait_cnt = 4'd4;
        read_chk("R5", 12'h043, 6, 1);
        read_chk("R5", 12'h043, 6, 0);
        cfg_wait_cnt = 4'd0;
        read_chk("R5", 12'h043, 2, 0);
    endtask

    task automatic t_policy_rsvd();
        cfg_read_mode = 2'd3; cfg_wait_cnt = 4'd1;
        read_chk("R6", 12'h054, 3, 1);
        read_chk("R6", 12'h054, 1, 0);
    endtask

    task automatic t_conflict();
        cfg_read_mode = 2'd0; cfg_wait_cnt = 4'd0;
        read_chk("R8", 12'h065, 2, 1);
        read_chk("R8", 12'h165, 2, 1);
        read_chk("R8", 12'h065, 2, 1);
        read_chk("R8", 12'h066, 2, 1);
        read_chk("R8", 12'h065, 1, 0);
    endtask

    task automatic t_bypass();
        cfg_read_mode = 2'd0; cfg_wait_cnt = 4'd1;
        read_chk("R7", 12'h077, 3, 1);
        read_chk("R7", 12'h077, 1, 0);
        @(negedge clk); cfg_cache_off = 1'b1;
        @(negedge clk);
        read_chk("R7", 12'h077, 3, 1);
        read_chk("R7", 12'h077, 3, 1);
        @(negedge clk); cfg_cache_off = 1'b0;
        read_chk("R7", 12'h077, 3, 1);
        read_chk("R7", 12'h077, 1, 0);
    endtask

    task automatic t_pulse();
        cfg_read_mode = 2'd0; cfg_wait_cnt = 4'd3;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_addr = 12'h088;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk("R9", "ready while busy", cpu_req_ready, 0);
        chk("R9", "rsp early", cpu_rsp_valid, 0);
        repeat (4) @(negedge clk);
        chk("R9", "rsp strobe", cpu_rsp_valid, 1);
        chk("R9", "ready at rsp", cpu_req_ready, 1);
        @(negedge clk);
        chk("R9", "strobe width", cpu_rsp_valid, 0);
    endtask

    task automatic t_sleep_access();
        int s, l, r;
        logic [31:0] d;
        cfg_read_mode = 2'd0; cfg_wait_cnt = 4'd0; cfg_sleep_mode = 2'd0;
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk);
        chk("R10", "lowpwr on entry", fl_lowpwr, 1);
        chk("R10", "ready asleep", cpu_req_ready, 0);
        repeat (3) @(negedge clk);
        sleep_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10", "lowpwr after exit", fl_lowpwr, 1);
        do_read(12'h099, s, l, d, r);
        chk("R10", "wake stall", s, 3);
        chk("R10", "data after wake", d, flash_word(12'h099));
        chk("R10", "lowpwr cleared", fl_lowpwr, 0);
    endtask

    task automatic t_sleep_exit();
        int s, l, r;
        logic [31:0] d;
        cfg_sleep_mode = 2'd1;
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk);
        chk("R11", "lowpwr on entry", fl_lowpwr, 1);
        sleep_req = 1'b0;
        @(negedge clk);
        chk("R11", "lowpwr drop", fl_lowpwr, 0);
        chk("R11", "ready waking", cpu_req_ready, 0);
        @(negedge clk);
        chk("R11", "ready waking 2", cpu_req_ready, 0);
        @(negedge clk);
        chk("R11", "ready after wake", cpu_req_ready, 1);
        do_read(12'h0AA, s, l, d, r);
        chk("R11", "no stall", s, 0);
    endtask

    task automatic t_sleep_off(input logic [1:0] m);
        int s, l, r;
        logic [31:0] d;
        cfg_sleep_mode = m;
        @(negedge clk); sleep_req = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12", "lowpwr stays off", fl_lowpwr, 0);
        do_read(12'h0B0 + 12'(m), s, l, d, r);
        chk("R12", "stall in sleep", s, 0);
        chk("R12", "data in sleep", d, flash_word(12'h0B0 + 12'(m)));
        chk("R12", "lowpwr after read", fl_lowpwr, 0);
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_policy_fast();
        t_policy_lowpw();
        t_policy_const();
        t_policy_rsvd();
        t_conflict();
        t_bypass();
        t_pulse();
        t_sleep_access();
        t_sleep_exit();
        t_sleep_off(2'd3);
        t_sleep_off(2'd2);
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

endmodule